// File: doc/BRIEF.md
# Segmented paging address translator

This block turns a virtual address made of a segment number, a page number inside that segment and a displacement into a real address. It first looks the (segment, page) pair up in a small fully associative map of recently used translations. When the pair is present, the stored frame number is joined to the displacement and returned on the next cycle without touching memory.

When the pair is absent, the block walks two levels of tables through a single memory read port. The first level is a segment table whose position is held in a writable origin register. Its entry gives the base of that segment's own page table and the segment length in pages. The page number is checked against that length, and the page-table entry is then read to obtain the frame number. A successful walk stores the result in the map, replacing entries in rotating order.

A length violation returns an addressing-error response and no address. A clear valid bit in either table entry returns a fault response. Writing the origin register discards every stored translation, because the tables it points at may have changed.

Top module: `segpage_xlate`

## Requirements
- R1: After reset, rsp_valid is low, req_ready is high and the map holds no translation, so the first request always performs a table walk.
- R2: The virtual address is {segment[3:0], page[5:0], displacement[9:0]}, with the segment in the top bits. The real address of a successful response is {frame[11:0], displacement[9:0]}. An error or fault response carries a real address of zero.
- R3: The map is searched first. On a hit the response (status 2'b00) is valid in the cycle after acceptance, no memory read is issued, and the cached frame is returned even if the tables in memory have since been changed.
- R4: The segment-table entry is read at byte address origin + 4*segment. Its fields are bit 31 valid, bits [22:16] length in pages, and bits [15:0] the page-table base byte address.
- R5: The page-table entry is read at byte address base + 4*page. Its fields are bit 31 valid and bits [11:0] frame. Read data arrives in the cycle after mem_rd_en.
- R6: If page >= length, the response has status 2'b10 (addressing error). It is valid three cycles after acceptance, and the page table is not read.
- R7: A clear valid bit in the segment-table entry or the page-table entry gives status 2'b11 (fault).
- R8: A successful walk responds with status 2'b00 five cycles after acceptance and writes (segment, page, frame) into the map. Error and fault results are not stored.
- R9: The map holds 8 entries filled in rotating order. The ninth fill after an empty map replaces the first entry filled.
- R10: A write on the origin port sets the origin used by later walks and empties the map. The rotating fill position restarts at the first entry.
- R11: req_ready is low from the cycle after a missing request is accepted until its response, and memory reads are never issued on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 20 | Virtual address {segment, page, displacement} |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_status | output | 2 | 00 ok, 10 addressing error, 11 fault |
| rsp_raddr | output | 22 | Real address {frame, displacement} |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 16 | Memory read byte address |
| mem_rd_data | input | 32 | Read data, valid the cycle after the strobe |
| org_we | input | 1 | Origin register write strobe |
| org_wdata | input | 16 | New segment-table origin byte address |

## Verification
The bench first changes a page-table entry that is already cached and asks for it again. A design that walks on a hit would return the new frame instead of the cached one and would show memory reads. It probes the last page below a segment's length and the first page at it. An off-by-one length compare would fault the legal page or read the page table for the illegal one. It then fills nine distinct pages to show that the oldest translation is evicted, and repeats a faulting request to show that faults are not cached. Last, it rewrites the origin: a map that survives the write would return a translation from the old tables.

// File: rtl/segpage_pkg.sv
package segpage_pkg;
    typedef enum logic [1:0] {
        ST_OK    = 2'b00,
        ST_ADDR  = 2'b10,
        ST_FAULT = 2'b11
    } xl_status_e;

    typedef enum logic [2:0] {
        W_IDLE,
        W_STE,
        W_STE_W,
        W_PTE,
        W_PTE_W
    } walk_st_e;

    localparam int ENTRY_VALID_BIT = 31;
    localparam int SEG_LEN_LSB     = 16;
endpackage

// File: rtl/segpage_amap.sv
module segpage_amap #(
    parameter int N   = 8,
    parameter int S_W = 4,
    parameter int P_W = 6,
    parameter int F_W = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [S_W-1:0] lk_seg,
    input  logic [P_W-1:0] lk_page,
    output logic           lk_hit,
    output logic [F_W-1:0] lk_frame,
    input  logic           fill_en,
    input  logic [S_W-1:0] fill_seg,
    input  logic [P_W-1:0] fill_page,
    input  logic [F_W-1:0] fill_frame,
    input  logic           flush
);
    localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic           v;
        logic [S_W-1:0] s;
        logic [P_W-1:0] p;
        logic [F_W-1:0] f;
    } ent_t;

    typedef struct packed {
        ent_t [N-1:0]     ent;
        logic [PTR_W-1:0] ptr;
    } st_t;

    st_t st_d, st_q;
    logic [N-1:0] match;
    logic [N-1:0] vbits;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = st_q.ent[g].v && (st_q.ent[g].s == lk_seg) &&
                          (st_q.ent[g].p == lk_page);
        assign vbits[g] = st_q.ent[g].v;
    end

    assign lk_hit = |match;

    always_comb begin
        lk_frame = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) lk_frame = lk_frame | st_q.ent[i].f;
        end
    end

    always_comb begin
        st_d = st_q;
        if (flush) begin
            for (int i = 0; i < N; i++) st_d.ent[i].v = 1'b0;
            st_d.ptr = '0;
        end else if (fill_en) begin
            st_d.ent[st_q.ptr] = '{v: 1'b1, s: fill_seg, p: fill_page, f: fill_frame};
            st_d.ptr = (st_q.ptr == PTR_W'(N - 1)) ? '0 : st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9: a lookup never matches two entries
    a_r9_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // R10: an origin write leaves no valid entry
    a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> ($countones(vbits) == 0));
endmodule

// File: rtl/segpage_walk.sv
module segpage_walk
    import segpage_pkg::*;
#(
    parameter int S_W = 4,
    parameter int P_W = 6,
    parameter int D_W = 10,
    parameter int F_W = 12,
    parameter int AW  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [S_W-1:0]     in_seg,
    input  logic [P_W-1:0]     in_page,
    input  logic [D_W-1:0]     in_disp,
    input  logic               hit,
    input  logic [F_W-1:0]     hit_frame,
    input  logic [AW-1:0]      origin,
    output logic               idle,
    output logic               mem_rd_en,
    output logic [AW-1:0]      mem_rd_addr,
    input  logic [31:0]        mem_rd_data,
    output logic               fill_en,
    output logic [S_W-1:0]     fill_seg,
    output logic [P_W-1:0]     fill_page,
    output logic [F_W-1:0]     fill_frame,
    output logic               rsp_valid,
    output logic [1:0]         rsp_status,
    output logic [F_W+D_W-1:0] rsp_raddr
);
    localparam int LEN_W = P_W + 1;

    typedef struct packed {
        walk_st_e           state;
        logic [S_W-1:0]     seg;
        logic [P_W-1:0]     page;
        logic [D_W-1:0]     disp;
        logic [AW-1:0]      base;
        logic               rv;
        xl_status_e         rs;
        logic [F_W+D_W-1:0] ra;
    } st_t;

    st_t st_d, st_q;

    logic             ent_valid;
    logic [LEN_W-1:0] seg_len;
    logic             page_ok;
    logic             unused_bits;

    assign ent_valid   = mem_rd_data[ENTRY_VALID_BIT];
    assign seg_len     = mem_rd_data[SEG_LEN_LSB +: LEN_W];
    assign page_ok     = {1'b0, st_q.page} < seg_len;
    assign unused_bits = ^mem_rd_data;

    always_comb begin
        st_d        = st_q;
        st_d.rv     = 1'b0;
        st_d.rs     = ST_OK;
        st_d.ra     = '0;
        mem_rd_en   = 1'b0;
        mem_rd_addr = '0;
        fill_en     = 1'b0;
        fill_seg    = st_q.seg;
        fill_page   = st_q.page;
        fill_frame  = mem_rd_data[F_W-1:0];
        unique case (st_q.state)
            W_IDLE: begin
                if (start) begin
                    st_d.seg  = in_seg;
                    st_d.page = in_page;
                    st_d.disp = in_disp;
                    if (hit) begin
                        st_d.rv = 1'b1;
                        st_d.ra = {hit_frame, in_disp};
                    end else begin
                        st_d.state = W_STE;
                    end
                end
            end
            W_STE: begin
                mem_rd_en   = 1'b1;
                mem_rd_addr = origin + AW'({st_q.seg, 2'b00});
                st_d.state  = W_STE_W;
            end
            W_STE_W: begin
                if (!ent_valid) begin
                    st_d.rv    = 1'b1;
                    st_d.rs    = ST_FAULT;
                    st_d.state = W_IDLE;
                end else if (!page_ok) begin
                    st_d.rv    = 1'b1;
                    st_d.rs    = ST_ADDR;
                    st_d.state = W_IDLE;
                end else begin
                    st_d.base  = mem_rd_data[AW-1:0];
                    st_d.state = W_PTE;
                end
            end
            W_PTE: begin
                mem_rd_en   = 1'b1;
                mem_rd_addr = st_q.base + AW'({st_q.page, 2'b00});
                st_d.state  = W_PTE_W;
            end
            W_PTE_W: begin
                st_d.rv    = 1'b1;
                st_d.state = W_IDLE;
                if (!ent_valid) begin
                    st_d.rs = ST_FAULT;
                end else begin
                    st_d.ra = {mem_rd_data[F_W-1:0], st_q.disp};
                    fill_en = 1'b1;
                end
            end
            default: st_d.state = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= W_IDLE;
            st_q.rs    <= ST_OK;
        end else begin
            st_q <= st_d;
        end
    end

    assign idle       = (st_q.state == W_IDLE);
    assign rsp_valid  = st_q.rv;
    assign rsp_status = st_q.rs;
    assign rsp_raddr  = st_q.ra;

    // R7: an invalid segment entry ends the walk with a fault
    a_r7_ste_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == W_STE_W && !ent_valid) |=> (rsp_valid && rsp_status == ST_FAULT));

    // R6: a page at or past the length gives an addressing error and no page-table read
    a_r6_len_error: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == W_STE_W && ent_valid && !page_ok) |=>
        (rsp_valid && rsp_status == ST_ADDR && !mem_rd_en));

    // R11: reads are spaced by at least one cycle
    a_r11_read_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);
endmodule

// File: rtl/segpage_xlate.sv
module segpage_xlate
    import segpage_pkg::*;
#(
    parameter int S_W  = 4,
    parameter int P_W  = 6,
    parameter int D_W  = 10,
    parameter int F_W  = 12,
    parameter int AW   = 16,
    parameter int MAPN = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [S_W+P_W+D_W-1:0]   req_vaddr,
    output logic                     rsp_valid,
    output logic [1:0]               rsp_status,
    output logic [F_W+D_W-1:0]       rsp_raddr,
    output logic                     mem_rd_en,
    output logic [AW-1:0]            mem_rd_addr,
    input  logic [31:0]              mem_rd_data,
    input  logic                     org_we,
    input  logic [AW-1:0]            org_wdata
);
    localparam int VA_W = S_W + P_W + D_W;

    logic [AW-1:0]  org_d, org_q;
    logic [S_W-1:0] va_seg;
    logic [P_W-1:0] va_page;
    logic [D_W-1:0] va_disp;
    logic           req_fire;
    logic           lk_hit;
    logic [F_W-1:0] lk_frame;
    logic           fill_en;
    logic [S_W-1:0] fill_seg;
    logic [P_W-1:0] fill_page;
    logic [F_W-1:0] fill_frame;
    logic           walk_idle;

    assign va_seg   = req_vaddr[VA_W-1 -: S_W];
    assign va_page  = req_vaddr[D_W +: P_W];
    assign va_disp  = req_vaddr[D_W-1:0];
    assign req_fire = req_valid && req_ready;
    assign req_ready = walk_idle;

    always_comb begin
        org_d = org_we ? org_wdata : org_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) org_q <= '0;
        else        org_q <= org_d;
    end

    segpage_amap #(.N(MAPN), .S_W(S_W), .P_W(P_W), .F_W(F_W)) u_amap (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_seg     (va_seg),
        .lk_page    (va_page),
        .lk_hit     (lk_hit),
        .lk_frame   (lk_frame),
        .fill_en    (fill_en),
        .fill_seg   (fill_seg),
        .fill_page  (fill_page),
        .fill_frame (fill_frame),
        .flush      (org_we)
    );

    segpage_walk #(.S_W(S_W), .P_W(P_W), .D_W(D_W), .F_W(F_W), .AW(AW)) u_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (req_fire),
        .in_seg      (va_seg),
        .in_page     (va_page),
        .in_disp     (va_disp),
        .hit         (lk_hit),
        .hit_frame   (lk_frame),
        .origin      (org_q),
        .idle        (walk_idle),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_data (mem_rd_data),
        .fill_en     (fill_en),
        .fill_seg    (fill_seg),
        .fill_page   (fill_page),
        .fill_frame  (fill_frame),
        .rsp_valid   (rsp_valid),
        .rsp_status  (rsp_status),
        .rsp_raddr   (rsp_raddr)
    );

    // R2: failed translations never expose an address
    a_r2_err_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status != ST_OK) |-> (rsp_raddr == '0));

    // R3: a hit answers next cycle without a memory read
    a_r3_hit_no_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_fire && lk_hit) |=> (rsp_valid && !mem_rd_en && req_ready));
endmodule

// File: tb/segpage_xlate_bench.sv
module segpage_xlate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [19:0] req_vaddr = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_status;
    logic [21:0] rsp_raddr;
    logic        mem_rd_en;
    logic [15:0] mem_rd_addr;
    logic [31:0] mem_rd_data = '0;
    logic        org_we = 1'b0;
    logic [15:0] org_wdata = '0;

    int n_checks = 0;
    int n_fail   = 0;
    int nreads   = 0;
    bit done     = 0;

    int mem [int];
    int org_m;
    int ms [8];
    int mp [8];
    int mf [8];
    bit mv [8];
    int mptr;

    always #5 clk = ~clk;

    segpage_xlate u_segpage_xlate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
        .rsp_raddr(rsp_raddr), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .org_we(org_we), .org_wdata(org_wdata)
    );

    function automatic int rdm(int a);
        if (mem.exists(a >> 2)) return mem[a >> 2];
        return 0;
    endfunction

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rd_data <= rdm(int'(mem_rd_addr));
            nreads = nreads + 1;
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_ste(int s, bit v, int len, int base);
        mem[(org_m + 4 * s) >> 2] = (int'(v) << 31) | (len << 16) | base;
    endtask

    task automatic set_pte(int base, int p, bit v, int frame);
        mem[(base + 4 * p) >> 2] = (int'(v) << 31) | frame;
    endtask

    task automatic wr_org(int o);
        @(negedge clk);
        org_we = 1'b1;
        org_wdata = 16'(o);
        @(negedge clk);
        org_we = 1'b0;
        org_m = o;
        for (int i = 0; i < 8; i++) mv[i] = 0;
        mptr = 0;
    endtask

    task automatic xlate(int s, int p, int d, string tag);
        int e_st, e_ra, e_lat, e_rd, ste, pte, cnt;
        bit hit;
        hit = 0;
        e_ra = 0;
        for (int i = 0; i < 8; i++) begin
            if (mv[i] && ms[i] == s && mp[i] == p) begin
                hit = 1;
                e_ra = (mf[i] << 10) | d;
            end
        end
        if (hit) begin
            e_st = 0; e_lat = 1; e_rd = 0;
        end else begin
            ste = rdm(org_m + 4 * s);
            if (ste[31] == 1'b0) begin
                e_st = 3; e_lat = 3; e_rd = 1;
            end else if (p >= ((ste >> 16) & 32'h7f)) begin
                e_st = 2; e_lat = 3; e_rd = 1;
            end else begin
                pte = rdm((ste & 32'hffff) + 4 * p);
                e_lat = 5; e_rd = 2;
                if (pte[31] == 1'b0) begin
                    e_st = 3;
                end else begin
                    e_st = 0;
                    e_ra = ((pte & 32'hfff) << 10) | d;
                    ms[mptr] = s; mp[mptr] = p; mf[mptr] = pte & 32'hfff; mv[mptr] = 1;
                    mptr = (mptr + 1) % 8;
                end
            end
        end
        @(negedge clk);
        chk(req_ready == 1'b1, {tag, " R11 ready before request"}, int'(req_ready), 1);
        req_valid = 1'b1;
        req_vaddr = {4'(s), 6'(p), 10'(d)};
        nreads = 0;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cnt = 1;
        if (!hit) chk(req_ready == 1'b0, {tag, " R11 ready low in walk"}, int'(req_ready), 0);
        while (!rsp_valid && cnt < 20) begin
            @(negedge clk);
            cnt++;
        end
        chk(cnt == e_lat, {tag, " latency"}, cnt, e_lat);
        chk(int'(rsp_status) == e_st, {tag, " status"}, int'(rsp_status), e_st);
        chk(int'(rsp_raddr) == e_ra, {tag, " real address"}, int'(rsp_raddr), e_ra);
        chk(nreads == e_rd, {tag, " memory reads"}, nreads, e_rd);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        org_m = 0;
        mptr = 0;
        for (int i = 0; i < 8; i++) mv[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R1 no response after reset", int'(rsp_valid), 0);
        chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);

        org_m = 32'h100;
        set_ste(0, 1, 4, 32'h400);
        for (int p = 0; p < 4; p++) set_pte(32'h400, p, p != 2, 32'h0a0 + p);
        set_ste(1, 0, 4, 32'h600);
        set_ste(2, 1, 64, 32'h800);
        for (int p = 0; p < 64; p++) set_pte(32'h800, p, 1, 32'h300 + p);
        set_ste(15, 1, 64, 32'hc00);
        set_pte(32'hc00, 63, 1, 32'hfff);
        wr_org(32'h100);

        xlate(0, 1, 32'h155, "R1 R4 R5 R8 first walk");
        xlate(0, 1, 32'h3ff, "R3 hit");
        set_pte(32'h400, 1, 1, 32'h7ff);
        xlate(0, 1, 5, "R3 hit keeps cached frame");
        xlate(0, 3, 7, "R6 last legal page");
        xlate(0, 4, 0, "R6 page equals length");
        xlate(0, 63, 1, "R6 page far past length");
        xlate(1, 0, 0, "R7 segment entry invalid");
        xlate(0, 2, 9, "R7 page entry invalid");
        xlate(0, 2, 9, "R8 fault not cached");
        xlate(15, 63, 32'h2aa, "R2 R4 top segment top page");
        for (int p = 0; p < 6; p++) xlate(2, p, p, "R9 fill");
        xlate(0, 1, 1, "R9 oldest evicted");
        xlate(0, 3, 2, "R9 second oldest evicted");
        xlate(2, 5, 3, "R9 recent entry kept");

        org_m = 32'h200;
        set_ste(0, 1, 8, 32'ha00);
        set_pte(32'ha00, 1, 1, 32'h123);
        wr_org(32'h200);
        xlate(0, 1, 32'h0f0, "R10 new origin walk");
        xlate(0, 1, 32'h0f1, "R10 refilled hit");

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule